// File: doc/BRIEF.md
# Pipelined Synchronous Dual-Port Memory

This block is a word-addressed storage array with two ports, A and B. Each port can read or write any word in any cycle, and the two ports can use the same word in the same cycle. Every request is captured in an input register at a rising clock edge. This includes the chip enables, the write flag, the lane enables, the address and the write data. The array is used during the following cycle. Read data passes through a second register, so a read needs two edges to return its result. A data-valid flag is returned with the data.

Each port has two chip enables of opposite polarity. A port is selected only when `x_ce0_n` is low and `x_ce1` is high. Each port runs a small state machine with three states: `PS_OFF`, `PS_WAKE` and `PS_ON`.

- `PS_OFF` is entered at reset and from any state after an edge that sees the port deselected.
- `PS_OFF` moves to `PS_WAKE` at an edge that sees the port selected.
- `PS_WAKE` moves to `PS_ON` at a selected edge and back to `PS_OFF` at a deselected edge.
- `PS_ON` stays in `PS_ON` while the port remains selected.

A request is carried out only while its port is in `PS_ON`. The request captured at the edge that enters `PS_WAKE` is the wake-up cycle, and it is dropped.

A word is 18 bits, made of two 9-bit lanes that can be written separately. The depth is 2^`ADDR_W`.

Top module: `dual_port_pipe_ram`

## Requirements
- R1: A request presented before rising edge k is captured at edge k. For a performed read, `x_rdata` and `x_rvalid` take the result just after edge k+1 and hold it until edge k+2.
- R2: A port is selected for a cycle only when `x_ce0_n` is 0 and `x_ce1` is 1. A high `x_ce0_n`, a low `x_ce1`, or both, deselect the port for that cycle and its request is not performed.
- R3: After reset, and after any deselected cycle, the first selected cycle is a wake-up cycle. Its request, read or write, is dropped. Requests in the following back-to-back selected cycles are performed.
- R4: A performed read (`x_we` = 0) returns the word stored at `x_addr` with `x_rvalid` = 1.
- R5: Whenever `x_rvalid` is 0, `x_rdata` is all zeros. The result slot of a write, a dropped request or a deselected cycle has `x_rvalid` = 0.
- R6: A performed write changes only the enabled lanes. `x_be[0]` guards bits 8:0 and `x_be[1]` guards bits 17:9, and a write with `x_be` = 00 changes nothing.
- R7: The two ports work independently in the same cycle. They can read the same word and both receive it, or write different words and both take effect.
- R8: When one port reads a word in the same cycle that the other port writes it, the reader gets the contents from before the write. Later reads get the new value.
- R9: When both ports write one word in the same cycle, that word's contents are undefined, and every other word keeps its value.
- R10: While reset is asserted, and after it until the first result slot, both ports output `x_rvalid` = 0 and `x_rdata` = 0, with both state machines in `PS_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_we | input | 1 | Port A write request (1 = write, 0 = read) |
| a_be | input | LANES | Port A lane write enables |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_rdata | output | LANES*LANE_W | Port A registered read data |
| a_rvalid | output | 1 | Port A read result valid |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_we | input | 1 | Port B write request (1 = write, 0 = read) |
| b_be | input | LANES | Port B lane write enables |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_rdata | output | LANES*LANE_W | Port B registered read data |
| b_rvalid | output | 1 | Port B read result valid |

## Verification
Every request has exactly one result slot on its own port, two rising edges after the inputs are presented. The bench drives one request per port just after a falling edge, which places its capture at the next rising edge. For each port it queues the expected result, tagged with the cycle count two edges later. The bench's own model of the wake-up rule decides whether the request is performed. The model reads first and writes afterwards, which gives the old-data result for a same-cycle overlap. The monitor compares each queued item at the falling edge of its due cycle, so every check samples the output register half a period after it has settled.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_WAKE = 2'd1,
        PS_ON   = 2'd2
    } port_state_e;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce0_n,
    input  logic                      ce1,
    input  logic                      we,
    input  logic [LANES-1:0]          be,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES-1:0]          wr_lanes,
    output logic                      do_read,
    output logic [ADDR_W-1:0]         addr_q,
    output logic [LANES*LANE_W-1:0]   wdata_q,
    output logic                      rvalid
);

    localparam int DATA_W = LANES * LANE_W;

    port_state_e       st_q;
    port_state_e       st_nxt;
    logic              sel;
    logic              we_q;
    logic [LANES-1:0]  be_q;

    assign sel = ~ce0_n & ce1;

    // request capture register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            be_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            we_q    <= we;
            be_q    <= be;
            addr_q  <= addr;
            wdata_q <= wdata[DATA_W-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PS_OFF;
        end else begin
            st_q <= st_nxt;
        end
    end

    // transitions
    always_comb begin
        st_nxt = PS_OFF;
        unique case (st_q)
            PS_OFF:  st_nxt = sel ? PS_WAKE : PS_OFF;
            PS_WAKE: st_nxt = sel ? PS_ON   : PS_OFF;
            PS_ON:   st_nxt = sel ? PS_ON   : PS_OFF;
            default: st_nxt = PS_OFF;
        endcase
    end

    // request execution decode
    always_comb begin
        wr_lanes = '0;
        do_read  = 1'b0;
        unique case (st_q)
            PS_ON: begin
                wr_lanes = we_q ? be_q : '0;
                do_read  = ~we_q;
            end
            PS_OFF, PS_WAKE: begin
                wr_lanes = '0;
                do_read  = 1'b0;
            end
            default: begin
                wr_lanes = '0;
                do_read  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= do_read;
        end
    end

endmodule

// File: rtl/dpr_lane_store.sv
module dpr_lane_store #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wen,
    input  logic              a_ren,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [LANE_W-1:0] a_wd,
    output logic [LANE_W-1:0] a_rd,
    input  logic              b_wen,
    input  logic              b_ren,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [LANE_W-1:0] b_wd,
    output logic [LANE_W-1:0] b_rd
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    // single writer process; on a same-word collision the later statement wins
    always_ff @(posedge clk) begin
        if (a_wen) begin
            mem[a_addr] <= a_wd;
        end
        if (b_wen) begin
            mem[b_addr] <= b_wd;
        end
    end

    // output registers sample the array before this edge's writes land
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rd <= '0;
            b_rd <= '0;
        end else begin
            a_rd <= a_ren ? mem[a_addr] : '0;
            b_rd <= b_ren ? mem[b_addr] : '0;
        end
    end

endmodule

// File: rtl/dual_port_pipe_ram.sv
module dual_port_pipe_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     a_ce0_n,
    input  logic                     a_ce1,
    input  logic                     a_we,
    input  logic [LANES-1:0]         a_be,
    input  logic [ADDR_W-1:0]        a_addr,
    input  logic [LANES*LANE_W-1:0]  a_wdata,
    output logic [LANES*LANE_W-1:0]  a_rdata,
    output logic                     a_rvalid,
    input  logic                     b_ce0_n,
    input  logic                     b_ce1,
    input  logic                     b_we,
    input  logic [LANES-1:0]         b_be,
    input  logic [ADDR_W-1:0]        b_addr,
    input  logic [LANES*LANE_W-1:0]  b_wdata,
    output logic [LANES*LANE_W-1:0]  b_rdata,
    output logic                     b_rvalid
);

    localparam int DATA_W = LANES * LANE_W;

    logic [NUM_PORTS-1:0]              p_ce0_n;
    logic [NUM_PORTS-1:0]              p_ce1;
    logic [NUM_PORTS-1:0]              p_we;
    logic [NUM_PORTS-1:0][LANES-1:0]   p_be;
    logic [NUM_PORTS-1:0][ADDR_W-1:0]  p_addr;
    logic [NUM_PORTS-1:0][DATA_W-1:0]  p_wdata;

    logic [NUM_PORTS-1:0][LANES-1:0]   p_wr_lanes;
    logic [NUM_PORTS-1:0]              p_do_read;
    logic [NUM_PORTS-1:0][ADDR_W-1:0]  p_addr_q;
    logic [NUM_PORTS-1:0][DATA_W-1:0]  p_wdata_q;
    logic [NUM_PORTS-1:0]              p_rvalid;
    logic [NUM_PORTS-1:0][DATA_W-1:0]  p_rdata;

    assign p_ce0_n = {b_ce0_n, a_ce0_n};
    assign p_ce1   = {b_ce1, a_ce1};
    assign p_we    = {b_we, a_we};
    assign p_be    = {b_be, a_be};
    assign p_addr  = {b_addr, a_addr};
    assign p_wdata = {b_wdata, a_wdata};

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
            dpr_port_ctrl #(
                .ADDR_W (ADDR_W),
                .LANES  (LANES),
                .LANE_W (LANE_W)
            ) u_ctrl (
                .clk      (clk),
                .rst_n    (rst_n),
                .ce0_n    (p_ce0_n[gp]),
                .ce1      (p_ce1[gp]),
                .we       (p_we[gp]),
                .be       (p_be[gp]),
                .addr     (p_addr[gp]),
                .wdata    (p_wdata[gp]),
                .wr_lanes (p_wr_lanes[gp]),
                .do_read  (p_do_read[gp]),
                .addr_q   (p_addr_q[gp]),
                .wdata_q  (p_wdata_q[gp]),
                .rvalid   (p_rvalid[gp])
            );
        end
    endgenerate

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            dpr_lane_store #(
                .ADDR_W (ADDR_W),
                .LANE_W (LANE_W)
            ) u_store (
                .clk    (clk),
                .rst_n  (rst_n),
                .a_wen  (p_wr_lanes[0][gl]),
                .a_ren  (p_do_read[0]),
                .a_addr (p_addr_q[0]),
                .a_wd   (p_wdata_q[0][gl*LANE_W +: LANE_W]),
                .a_rd   (p_rdata[0][gl*LANE_W +: LANE_W]),
                .b_wen  (p_wr_lanes[1][gl]),
                .b_ren  (p_do_read[1]),
                .b_addr (p_addr_q[1]),
                .b_wd   (p_wdata_q[1][gl*LANE_W +: LANE_W]),
                .b_rd   (p_rdata[1][gl*LANE_W +: LANE_W])
            );
        end
    endgenerate

    assign a_rdata  = p_rdata[0];
    assign b_rdata  = p_rdata[1];
    assign a_rvalid = p_rvalid[0];
    assign b_rvalid = p_rvalid[1];

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_ce0_n,
    input logic              a_ce1,
    input logic              a_we,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_rvalid,
    input logic              b_ce0_n,
    input logic              b_ce1,
    input logic              b_we,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_rvalid
);

    logic       a_sel;
    logic       b_sel;
    logic [1:0] edges_seen;

    assign a_sel = ~a_ce0_n & a_ce1;
    assign b_sel = ~b_ce0_n & b_ce1;

    // history depth guard: $past(.,3) is trusted only after three post-reset edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges_seen <= 2'd0;
        end else if (edges_seen != 2'd3) begin
            edges_seen <= edges_seen + 2'd1;
        end
    end

    AST_A_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rvalid && edges_seen == 2'd3) |-> ($past(a_sel, 2) && $past(a_sel, 3) && !$past(a_we, 2)))
        else $error("port A valid without a performed read"); // R3

    AST_A_VALID_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_seen == 2'd3 && $past(a_sel, 2) && $past(a_sel, 3) && !$past(a_we, 2)) |-> a_rvalid)
        else $error("port A read result missing"); // R1

    AST_A_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !a_rvalid |-> (a_rdata == '0))
        else $error("port A data not zero while idle"); // R5

    AST_B_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rvalid && edges_seen == 2'd3) |-> ($past(b_sel, 2) && $past(b_sel, 3) && !$past(b_we, 2)))
        else $error("port B valid without a performed read"); // R3

    AST_B_VALID_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_seen == 2'd3 && $past(b_sel, 2) && $past(b_sel, 3) && !$past(b_we, 2)) |-> b_rvalid)
        else $error("port B read result missing"); // R1

    AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !b_rvalid |-> (b_rdata == '0))
        else $error("port B data not zero while idle"); // R5

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (!a_rvalid && !b_rvalid))
        else $error("valid raised during reset"); // R10

endmodule

bind dual_port_pipe_ram dpr_checker #(.DATA_W(LANES * LANE_W)) u_dpr_chk (.*);

// File: tb/dual_port_pipe_ram_test.sv
module dual_port_pipe_ram_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int DW    = 18;
    localparam int WORDS = 1 << AW;

    typedef struct packed {
        logic          ce0_n;
        logic          ce1;
        logic          we;
        logic [1:0]    be;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic [31:0]   due;
        logic          port;
        logic          valid;
        logic          dc;
        logic [DW-1:0] data;
    } exp_t;

    logic          clk;
    logic          rst_n;
    logic          a_ce0_n, a_ce1, a_we;
    logic [1:0]    a_be;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_wdata, a_rdata;
    logic          a_rvalid;
    logic          b_ce0_n, b_ce1, b_we;
    logic [1:0]    b_be;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata, b_rdata;
    logic          b_rvalid;

    int   cyc    = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    logic [DW-1:0] mdl [WORDS];
    bit            unk [WORDS];
    int            mst [2];

    dual_port_pipe_ram #(.ADDR_W(AW), .LANES(2), .LANE_W(9)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_ce0_n(a_ce0_n), .a_ce1(a_ce1), .a_we(a_we), .a_be(a_be),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
        .b_ce0_n(b_ce0_n), .b_ce1(b_ce1), .b_we(b_we), .b_be(b_be),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic req_t rd(int a);
        req_t r;
        r = '{ce0_n: 1'b0, ce1: 1'b1, we: 1'b0, be: 2'b00, addr: AW'(a), wdata: '0};
        return r;
    endfunction

    function automatic req_t wr(int a, logic [DW-1:0] d, logic [1:0] be);
        req_t r;
        r = '{ce0_n: 1'b0, ce1: 1'b1, we: 1'b1, be: be, addr: AW'(a), wdata: d};
        return r;
    endfunction

    function automatic req_t off(int a, logic c0n, logic c1);
        req_t r;
        r = rd(a);
        r.ce0_n = c0n;
        r.ce1   = c1;
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(int i);
        return DW'(i * 9973 + 123);
    endfunction

    task automatic step(req_t ra, req_t rb, string tag);
        req_t rq[2];
        bit   perf[2];
        exp_t e;
        logic [DW-1:0] nv;
        @(negedge clk);
        #1;
        rq[0] = ra;
        rq[1] = rb;
        a_ce0_n = ra.ce0_n; a_ce1 = ra.ce1; a_we = ra.we; a_be = ra.be;
        a_addr = ra.addr; a_wdata = ra.wdata;
        b_ce0_n = rb.ce0_n; b_ce1 = rb.ce1; b_we = rb.we; b_be = rb.be;
        b_addr = rb.addr; b_wdata = rb.wdata;
        // reads see the array before this slot's writes (R8)
        for (int p = 0; p < 2; p++) begin
            if (!(!rq[p].ce0_n && rq[p].ce1)) mst[p] = 0;
            else if (mst[p] == 0)             mst[p] = 1;
            else                              mst[p] = 2;
            perf[p] = (mst[p] == 2);
            e.due  = 32'(cyc + 2);
            e.port = p[0];
            if (perf[p] && !rq[p].we) begin
                e.valid = 1'b1;
                e.data  = mdl[rq[p].addr];
                e.dc    = unk[rq[p].addr];
            end else begin
                e.valid = 1'b0;
                e.data  = '0;
                e.dc    = 1'b0;
            end
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        for (int p = 0; p < 2; p++) begin
            if (perf[p] && rq[p].we) begin
                nv = mdl[rq[p].addr];
                if (rq[p].be[0]) nv[8:0]  = rq[p].wdata[8:0];
                if (rq[p].be[1]) nv[17:9] = rq[p].wdata[17:9];
                mdl[rq[p].addr] = nv;
                if (rq[p].be == 2'b11) unk[rq[p].addr] = 1'b0;
            end
        end
        if (perf[0] && perf[1] && rq[0].we && rq[1].we && rq[0].addr == rq[1].addr
            && rq[0].be != 2'b00 && rq[1].be != 2'b00)
            unk[rq[0].addr] = 1'b1; // R9 collided word is left unchecked
    endtask

    // monitor: compare each queued result in its due cycle
    always @(negedge clk) begin
        exp_t e;
        string t;
        logic v;
        logic [DW-1:0] d;
        while (exp_q.size() > 0 && exp_q[0].due == 32'(cyc)) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            v = e.port ? b_rvalid : a_rvalid;
            d = e.port ? b_rdata  : a_rdata;
            checks++;
            if (v !== e.valid || (!e.dc && d !== e.data)) begin
                errors++;
                $display("FAIL %s port %s: got valid=%0b data=%h, expected valid=%0b data=%h%s",
                         t, e.port ? "B" : "A", v, d, e.valid, e.data,
                         e.dc ? " (data not compared)" : "");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mdl[i] = '0;
            unk[i] = 1'b1;
        end
        mst[0] = 0;
        mst[1] = 0;
        rst_n = 1'b0;
        a_ce0_n = 1'b1; a_ce1 = 1'b0; a_we = 1'b0; a_be = '0; a_addr = '0; a_wdata = '0;
        b_ce0_n = 1'b1; b_ce1 = 1'b0; b_we = 1'b0; b_be = '0; b_addr = '0; b_wdata = '0;
        repeat (3) @(negedge clk);
        // R10 outputs idle in reset
        checks++;
        if (a_rvalid !== 1'b0 || a_rdata !== '0) begin
            errors++;
            $display("FAIL R10 port A reset: got valid=%0b data=%h, expected valid=0 data=0", a_rvalid, a_rdata);
        end
        checks++;
        if (b_rvalid !== 1'b0 || b_rdata !== '0) begin
            errors++;
            $display("FAIL R10 port B reset: got valid=%0b data=%h, expected valid=0 data=0", b_rvalid, b_rdata);
        end
        rst_n = 1'b1;

        step(off(0, 1'b1, 1'b0), off(0, 1'b1, 1'b0), "R10 idle after reset");
        step(rd(0), rd(1), "R3 wake after reset");
        for (int i = 0; i < WORDS; i++)
            step(wr(i, pat(i), 2'b11), rd(i), "R4 R5 fill");
        for (int i = 0; i < WORDS; i++)
            step(rd(i), rd(WORDS - 1 - i), "R4 R7 readback");

        step(wr(3, 18'h3ffff, 2'b01), rd(8), "R6 low lane");
        step(wr(4, 18'h3ffff, 2'b10), rd(8), "R6 high lane");
        step(wr(5, 18'h3ffff, 2'b00), rd(8), "R6 no lane");
        step(rd(3), rd(4), "R6 lane readback");
        step(rd(5), rd(5), "R6 untouched word");

        step(wr(7, 18'h15a5a, 2'b11), rd(7), "R8 same-cycle read gets old");
        step(rd(0), rd(7), "R8 later read gets new");

        step(rd(9), rd(9), "R7 shared read");
        step(wr(10, 18'h0beef, 2'b11), wr(11, 18'h2cafe, 2'b11), "R5 R7 dual write");
        step(rd(11), rd(10), "R7 dual write readback");

        step(off(2, 1'b1, 1'b1), rd(2), "R2 ce0_n high deselects");
        step(rd(2), rd(2), "R3 wake read dropped");
        step(rd(2), rd(2), "R2 R3 resumed");
        step(rd(6), off(6, 1'b0, 1'b0), "R2 ce1 low deselects");
        step(rd(6), rd(6), "R3 wake read dropped");
        step(rd(6), rd(6), "R3 resumed");
        step(off(1, 1'b1, 1'b0), rd(1), "R2 both enables off");
        step(wr(12, 18'h11111, 2'b11), rd(1), "R3 wake write dropped");
        step(rd(12), rd(12), "R3 wake write had no effect");

        step(wr(13, 18'h00aaa, 2'b11), wr(13, 18'h3f555, 2'b11), "R9 collision");
        step(rd(12), rd(14), "R9 neighbours intact");
        step(rd(13), rd(13), "R9 collided word unchecked");

        step(rd(1), rd(2), "R1 two-edge latency");
        step(rd(2), rd(1), "R1 back-to-back");
        step(off(0, 1'b1, 1'b0), off(0, 1'b1, 1'b0), "R5 deselected idle");
        step(off(0, 1'b1, 1'b0), off(0, 1'b1, 1'b0), "R5 deselected idle");

        repeat (4) @(negedge clk);
        #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule